// File: doc/BRIEF.md
# Flash Power Warm-Up Controller

This block decides when the control circuit of an on-chip flash memory is powered, and when the flash may be touched after power returns. Software holds a single control bit. Clearing it removes power at once. Setting it starts a warm-up counter, and a ready status bit rises when that counter overflows. The counter runs for 2^10 cycles on the fast clock or 2^3 cycles on the slow clock. The clock choice is captured when the warm-up starts.

Software may change the control bit only while the CPU is running code from RAM. A write made while running from flash is dropped. Two hardware events start a warm-up without software: a non-maskable interrupt that arrives while the bit is clear, and a STOP release when the bit was set going into STOP. In both cases the CPU is stalled until the flash is ready. An NMI that arrives during a warm-up started by software also stalls the CPU until that warm-up ends.

Until the flash is ready, every read of flash returns 8'hFF. A fetch in that state also raises a software-interrupt indication.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After reset, ctrl_o=1, ready_o=1, flash_pwr_o=1, cpu_wait_o=0 and swi_o=0. rdata_o passes flash_rdata_i through.
- R2: If reg_wr_i=1, exec_ram_i=1 and reg_wdata_i=0 while the flash is ready, then one cycle later ctrl_o=0, flash_pwr_o=0 and ready_o=0.
- R3: A write with exec_ram_i=0 leaves ctrl_o, ready_o and flash_pwr_o unchanged, whatever the value of reg_wdata_i.
- R4: If reg_wr_i=1, exec_ram_i=1 and reg_wdata_i=1 while powered off, then on the next cycle ctrl_o=1 and flash_pwr_o=1, with ready_o=0 and cpu_wait_o=0. ready_o rises exactly 2^FAST_EXP (1024) cycles after the start edge when slow_clk_sel_i=0, or 2^SLOW_EXP (8) cycles after it when slow_clk_sel_i=1.
- R5: slow_clk_sel_i is sampled only on the cycle a warm-up starts. Changing it during the warm-up does not alter the length of the warm-up.
- R6: While ready_o=0, rdata_o reads 8'hFF. While ready_o=1, rdata_o equals flash_rdata_i.
- R7: swi_o=1 exactly when flash_fetch_i=1 and ready_o=0.
- R8: An NMI while powered off sets ctrl_o=1 and starts a warm-up with cpu_wait_o=1 from the next cycle. cpu_wait_o falls on the same edge on which ready_o rises. An NMI while ready has no effect.
- R9: An NMI during a warm-up started by software raises cpu_wait_o on the next cycle. cpu_wait_o then stays high until ready_o rises.
- R10: stop_enter_i while ready removes flash power and keeps ctrl_o=1. The next stop_release_i starts a warm-up with cpu_wait_o=1.
- R11: While ctrl_o=0, neither stop_enter_i nor stop_release_i changes any output. The flash stays powered off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe for the control bit |
| reg_wdata_i | input | 1 | Value written to the control bit |
| exec_ram_i | input | 1 | The current instruction executes from RAM |
| nmi_i | input | 1 | Non-maskable interrupt request, one-cycle pulse |
| stop_enter_i | input | 1 | STOP mode entry strobe |
| stop_release_i | input | 1 | STOP release strobe, given after the oscillator warm-up |
| slow_clk_sel_i | input | 1 | 1 selects the slow-clock warm-up length |
| flash_fetch_i | input | 1 | The current flash access is an instruction fetch |
| flash_rdata_i | input | DW | Data from the flash array |
| ctrl_o | output | 1 | Control bit readback |
| ready_o | output | 1 | Warm-up done status |
| flash_pwr_o | output | 1 | Power enable to the flash control circuit |
| cpu_wait_o | output | 1 | Holds the CPU in wait |
| rdata_o | output | DW | Read data returned to the CPU |
| swi_o | output | 1 | Software-interrupt indication on a fetch from unpowered flash |

## Verification
The assertions assume the following about the inputs:
- Every strobe (write, NMI, STOP entry, STOP release) lasts exactly one cycle.
- A STOP release only follows a STOP entry.
- No register write arrives while cpu_wait_o holds the CPU.
- NMI and STOP strobes never fall in the same cycle.

The stimulus keeps to these rules. It drives each strobe alone for one cycle and returns it to zero before the next event. It issues writes only while the CPU is not stalled.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    PWR_OFF   = 2'd0,
    PWR_WARM  = 2'd1,
    PWR_READY = 2'd2,
    PWR_SLEEP = 2'd3
  } pwr_state_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/fpc_warmup_timer.sv
module fpc_warmup_timer #(
  parameter int FAST_EXP = 10,
  parameter int SLOW_EXP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic slow_sel_i,
  output logic done_o
);
  localparam int CW = (FAST_EXP > SLOW_EXP) ? FAST_EXP : SLOW_EXP;
  localparam logic [CW-1:0] FAST_LAST = {CW{1'b1}} >> (CW - FAST_EXP);
  localparam logic [CW-1:0] SLOW_LAST = {CW{1'b1}} >> (CW - SLOW_EXP);

  logic [CW-1:0] cnt_q;
  logic          sel_q;
  logic [CW-1:0] last;

  assign last   = sel_q ? SLOW_LAST : FAST_LAST;
  assign done_o = run_i && (cnt_q == last);

  // Clock choice is captured on the start edge and held until overflow.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      sel_q <= slow_sel_i;
    end else if (run_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= last));

  assert_sel_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(sel_q));
endmodule

// File: rtl/fpc_access_gate.sv
module fpc_access_gate #(
  parameter int DW = 8
) (
  input  logic          ready_i,
  input  logic          fetch_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          swi_o
);
  localparam logic [DW-1:0] BLANK = {DW{1'b1}};

  assign rdata_o = ready_i ? rdata_i : BLANK;
  assign swi_o   = fetch_i && !ready_i;
endmodule

// File: rtl/fpc_power_fsm.sv
module fpc_power_fsm
  import fpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       wdata_i,
  input  logic       exec_ram_i,
  input  logic       nmi_i,
  input  logic       stop_enter_i,
  input  logic       stop_release_i,
  input  logic       done_i,
  output pwr_state_e state_o,
  output logic       ctrl_o,
  output logic       stall_o,
  output logic       start_o
);
  pwr_state_e state_q, state_d;
  logic       ctrl_q, ctrl_d;
  logic       stall_q, stall_d;
  logic       wr_ok;

  assign wr_ok = wr_i && exec_ram_i;

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    stall_d = stall_q;
    unique case (state_q)
      PWR_READY: begin
        if (stop_enter_i) begin
          state_d = PWR_SLEEP;
        end else if (wr_ok && !wdata_i) begin
          state_d = PWR_OFF;
          ctrl_d  = 1'b0;
        end
      end
      PWR_SLEEP: begin
        if (stop_release_i) begin
          state_d = PWR_WARM;
          stall_d = 1'b1;
        end
      end
      PWR_OFF: begin
        if (stop_enter_i || stop_release_i) begin
          state_d = PWR_OFF;
        end else if (nmi_i) begin
          state_d = PWR_WARM;
          ctrl_d  = 1'b1;
          stall_d = 1'b1;
        end else if (wr_ok && wdata_i) begin
          state_d = PWR_WARM;
          ctrl_d  = 1'b1;
          stall_d = 1'b0;
        end
      end
      PWR_WARM: begin
        if (stop_enter_i) begin
          state_d = PWR_SLEEP;
          stall_d = 1'b0;
        end else if (done_i) begin
          state_d = PWR_READY;
          stall_d = 1'b0;
        end else if (nmi_i) begin
          stall_d = 1'b1;
        end else if (wr_ok && !wdata_i && !stall_q) begin
          state_d = PWR_OFF;
          ctrl_d  = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_READY;
      ctrl_q  <= 1'b1;
      stall_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      stall_q <= stall_d;
    end
  end

  assign state_o = state_q;
  assign ctrl_o  = ctrl_q;
  assign stall_o = stall_q;
  assign start_o = (state_d == PWR_WARM) && (state_q != PWR_WARM);

  assert_flash_wr_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !exec_ram_i && !nmi_i) |=> $stable(ctrl_q));

  assert_ready_from_warm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == PWR_READY) |-> $past(done_i));

  assert_nmi_wakes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWR_OFF && nmi_i && !stop_enter_i && !stop_release_i)
      |=> (state_q == PWR_WARM && stall_q && ctrl_q));

  assert_stall_in_warm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q |-> (state_q == PWR_WARM));

  assert_stop_keeps_ctrl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWR_READY && stop_enter_i) |=> (state_q == PWR_SLEEP && ctrl_q));

  assert_off_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PWR_OFF && (stop_enter_i || stop_release_i)) |=> (state_q == PWR_OFF));
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import fpc_pkg::*;
#(
  parameter int FAST_EXP = 10,
  parameter int SLOW_EXP = 3,
  parameter int DW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_wdata_i,
  input  logic          exec_ram_i,
  input  logic          nmi_i,
  input  logic          stop_enter_i,
  input  logic          stop_release_i,
  input  logic          slow_clk_sel_i,
  input  logic          flash_fetch_i,
  input  logic [DW-1:0] flash_rdata_i,
  output logic          ctrl_o,
  output logic          ready_o,
  output logic          flash_pwr_o,
  output logic          cpu_wait_o,
  output logic [DW-1:0] rdata_o,
  output logic          swi_o
);
  pwr_state_e state;
  logic       start, done;

  fpc_power_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (reg_wr_i),
    .wdata_i       (reg_wdata_i),
    .exec_ram_i    (exec_ram_i),
    .nmi_i         (nmi_i),
    .stop_enter_i  (stop_enter_i),
    .stop_release_i(stop_release_i),
    .done_i        (done),
    .state_o       (state),
    .ctrl_o        (ctrl_o),
    .stall_o       (cpu_wait_o),
    .start_o       (start)
  );

  fpc_warmup_timer #(
    .FAST_EXP(FAST_EXP),
    .SLOW_EXP(SLOW_EXP)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .run_i     (state == PWR_WARM),
    .slow_sel_i(slow_clk_sel_i),
    .done_o    (done)
  );

  assign ready_o     = (state == PWR_READY);
  assign flash_pwr_o = (state == PWR_WARM) || (state == PWR_READY);

  fpc_access_gate #(.DW(DW)) i_gate (
    .ready_i(ready_o),
    .fetch_i(flash_fetch_i),
    .rdata_i(flash_rdata_i),
    .rdata_o(rdata_o),
    .swi_o  (swi_o)
  );

  assert_ram_clear_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && reg_wr_i && exec_ram_i && !reg_wdata_i && !stop_enter_i)
      |=> (!flash_pwr_o && !ctrl_o));

  assert_unpowered_not_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_pwr_o |-> !ready_o);

  assert_blank_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (rdata_o == {DW{1'b1}}));
endmodule

// File: tb/test_flash_pwr_ctrl.sv
`timescale 1ns/1ps
module test_flash_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr = 0, reg_wdata = 0, exec_ram = 0, nmi = 0;
  logic       stop_enter = 0, stop_release = 0, slow_sel = 0, fetch = 0;
  logic [7:0] frd = 8'h5A;
  logic       ctrl, ready, pwr, cwait, swi;
  logic [7:0] rdata;

  always #2 clk = ~clk;

  flash_pwr_ctrl i_flash_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .exec_ram_i(exec_ram), .nmi_i(nmi), .stop_enter_i(stop_enter),
    .stop_release_i(stop_release), .slow_clk_sel_i(slow_sel),
    .flash_fetch_i(fetch), .flash_rdata_i(frd), .ctrl_o(ctrl), .ready_o(ready),
    .flash_pwr_o(pwr), .cpu_wait_o(cwait), .rdata_o(rdata), .swi_o(swi)
  );

  typedef struct {
    int          at;
    string       req;
    logic [12:0] exp;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [12:0] mk(logic c, logic r, logic p, logic w, logic s);
    return {c, r, p, w, s, (r ? 8'h5A : 8'hFF)};
  endfunction

  // monitor: pop and compare at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() != 0 && sb_q[0].at <= cyc) begin
      item_t it;
      logic [12:0] act;
      it  = sb_q.pop_front();
      act = {ctrl, ready, pwr, cwait, swi, rdata};
      checks++;
      if (it.at != cyc || act !== it.exp) begin
        fails++;
        $display("FAIL %s cycle %0d: actual %h expected %h", it.req, cyc, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic expect_at(int at, string req, logic [12:0] e);
    item_t it;
    it.at = at; it.req = req; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic ram_write(logic v);
    reg_wr = 1; reg_wdata = v; exec_ram = 1;
    tick(1);
    reg_wr = 0; exec_ram = 0;
  endtask

  task automatic power_off();
    int c;
    c = cyc;
    expect_at(c + 1, "R2", mk(0, 0, 0, 0, 0));
    ram_write(1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    expect_at(cyc + 1, "R1", mk(1, 1, 1, 0, 0));
    tick(1);

    // R3 clear attempt from flash while ready
    c = cyc;
    reg_wr = 1; reg_wdata = 0; exec_ram = 0;
    expect_at(c + 1, "R3", mk(1, 1, 1, 0, 0));
    tick(1);
    reg_wr = 0;
    expect_at(c + 2, "R3", mk(1, 1, 1, 0, 0));
    tick(1);

    power_off();   // R2, R6 blank read

    // R7 fetch while off
    c = cyc;
    fetch = 1;
    expect_at(c + 1, "R7", mk(0, 0, 0, 0, 1));
    tick(1);
    fetch = 0;
    expect_at(c + 2, "R7", mk(0, 0, 0, 0, 0));
    tick(1);

    // R3 set attempt from flash while off
    c = cyc;
    reg_wr = 1; reg_wdata = 1; exec_ram = 0;
    expect_at(c + 1, "R3", mk(0, 0, 0, 0, 0));
    tick(1);
    reg_wr = 0;
    expect_at(c + 2, "R3", mk(0, 0, 0, 0, 0));
    tick(1);

    // R11 STOP with bit clear
    c = cyc;
    stop_enter = 1;
    expect_at(c + 1, "R11", mk(0, 0, 0, 0, 0));
    tick(1);
    stop_enter = 0;
    tick(2);
    c = cyc;
    stop_release = 1;
    expect_at(c + 1, "R11", mk(0, 0, 0, 0, 0));
    tick(1);
    stop_release = 0;
    expect_at(c + 2, "R11", mk(0, 0, 0, 0, 0));
    tick(1);

    // R4/R5 slow warm-up, select flipped during warm-up
    c = cyc;
    slow_sel = 1;
    expect_at(c + 1, "R4", mk(1, 0, 1, 0, 0));
    expect_at(c + 8, "R5", mk(1, 0, 1, 0, 0));
    expect_at(c + 9, "R5", mk(1, 1, 1, 0, 0));
    ram_write(1'b1);
    slow_sel = 0;
    tick(9);

    // R4 fast warm-up
    power_off();
    c = cyc;
    slow_sel = 0;
    expect_at(c + 1, "R4", mk(1, 0, 1, 0, 0));
    expect_at(c + 1024, "R4", mk(1, 0, 1, 0, 0));
    expect_at(c + 1025, "R4", mk(1, 1, 1, 0, 0));
    ram_write(1'b1);
    slow_sel = 1;
    tick(1025);

    // R8 NMI while off
    power_off();
    c = cyc;
    slow_sel = 1;
    nmi = 1;
    expect_at(c + 1, "R8", mk(1, 0, 1, 1, 0));
    expect_at(c + 8, "R8", mk(1, 0, 1, 1, 0));
    expect_at(c + 9, "R8", mk(1, 1, 1, 0, 0));
    tick(1);
    nmi = 0;
    tick(9);
    // R8 NMI while ready: no effect
    c = cyc;
    nmi = 1;
    expect_at(c + 1, "R8", mk(1, 1, 1, 0, 0));
    tick(1);
    nmi = 0;
    tick(1);

    // R9 NMI during software warm-up
    power_off();
    c = cyc;
    slow_sel = 1;
    expect_at(c + 1, "R9", mk(1, 0, 1, 0, 0));
    ram_write(1'b1);
    nmi = 1;
    expect_at(c + 2, "R9", mk(1, 0, 1, 1, 0));
    expect_at(c + 8, "R9", mk(1, 0, 1, 1, 0));
    expect_at(c + 9, "R9", mk(1, 1, 1, 0, 0));
    tick(1);
    nmi = 0;
    tick(8);

    // R10 STOP with bit set, then release
    c = cyc;
    stop_enter = 1;
    expect_at(c + 1, "R10", mk(1, 0, 0, 0, 0));
    tick(1);
    stop_enter = 0;
    tick(3);
    c = cyc;
    stop_release = 1;
    expect_at(c + 1, "R10", mk(1, 0, 1, 1, 0));
    expect_at(c + 9, "R10", mk(1, 1, 1, 0, 0));
    tick(1);
    stop_release = 0;
    tick(9);

    tick(3);
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule